// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block is the control slice of an 8-bit accumulator processor that decides, whenever the core fetches an opcode, whether the fetch is hijacked by a reset request, a non-maskable interrupt or a maskable interrupt. A hijacked fetch has its opcode thrown away and replaced by the break opcode 0x00. The block then takes the bus and runs the common entry sequence. That sequence is one operand cycle, three stack cycles and two vector reads. It ends by handing the core a new program counter.

A software break (opcode 0x00 with no request pending) runs the same sequence. The program counter it pushes has skipped the padding byte after the opcode. The pushed status byte carries a marker bit so that a handler can tell software entry from hardware entry. A reset walks the stack pointer through the same three stack cycles but keeps the bus in read mode, so that memory is not modified. The block also owns the status and stack-pointer registers. The overflow flag can be set from a dedicated pin, and the core may load the status byte.

Top module: `irq_entry_seq`

## Requirements
- R1: After `rst`, `p_o` is 0x20 (only the always-one bit 5 set), `s_o` is 0xFF, `bus_act_o` and `force_o` are 0 and `rw_o` is 1.
- R2: A fetch cycle takes the highest pending request, in the order reset, then NMI, then IRQ. It then reads the vector pair in page 0xFF at offset 0xFC for reset, 0xFA for NMI and 0xFE for IRQ or software break.
- R3: IRQ (level on `irq_n` low during the fetch) is taken only while status bit 2 (I) is 0. A masked IRQ with a nonzero opcode starts no sequence.
- R4: `force_o` is 1 during every cycle of a hardware-requested sequence, including one whose fetched opcode was 0x00. It is 0 for a software break.
- R5: The stack cycles address page 0x01 at S, then S-1, then S-2, carrying PC high, PC low and the status byte. `s_o` ends three lower.
- R6: For reset, the three stack cycles keep `rw_o` at 1 (no write). For the other entries they write (`rw_o` 0).
- R7: The pushed status byte has bit 5 set. Bit 4 (break marker) is 1 only for a software break.
- R8: The cycle after the fetch reads address opcode+1. A software break pushes opcode address + 2. A hardware entry pushes the opcode address.
- R9: The I flag is 1 by the last vector cycle. One cycle later `pc_load_o` pulses for a single cycle, with `pc_o` = {byte at offset+1, byte at offset}.
- R10: NMI is taken on a falling edge of `nmi_n`. Holding the pin low causes only one entry.
- R11: A reset request is cleared once its vector has been loaded, while `res_n` is high. An NMI left pending behind a reset is kept and taken at the next fetch.
- R12: A cycle with `so_n` low sets status bit 6 (V) at the next edge.
- R13: A fetch cycle with `rdy` low is not examined: no sequence starts, and pending requests stay pending.
- R14: `p_load_i` writes `p_data_i` into the status register with bit 4 forced to 0 and bit 5 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| res_n | input | 1 | Reset request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| so_n | input | 1 | Set-overflow pin, active low |
| rdy | input | 1 | Ready; low suppresses the fetch decision |
| fetch_i | input | 1 | Core is in an opcode fetch cycle |
| pc_i | input | 16 | Address of the opcode being fetched |
| data_i | input | 8 | Read data bus (opcode during fetch) |
| p_load_i | input | 1 | Core loads the status register |
| p_data_i | input | 8 | Status value to load |
| addr_o | output | 16 | Bus address during the sequence |
| wdata_o | output | 8 | Write data during the sequence |
| rw_o | output | 1 | 1 read, 0 write |
| bus_act_o | output | 1 | Block owns the bus this cycle |
| force_o | output | 1 | Opcode was replaced by a forced break |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | One-cycle strobe for `pc_o` |
| p_o | output | 8 | Status register |
| s_o | output | 8 | Stack pointer |

## Verification
The bench builds the block with its default parameters: stack page 0x01, vector page 0xFF, and offsets 0xFA, 0xFC and 0xFE. With these values the high byte of the IRQ vector sits on the last address of the memory map. A software break placed on the last byte of a page makes the pushed return address cross into the next page. Several requests raised together in one scenario show the priority order, and show that an NMI left behind by a reset is taken at the following fetch.

// File: rtl/ies_pkg.sv
package ies_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // status bit positions (decoded by the core and by software)
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_R = 5;
    localparam int FL_V = 6;
    localparam int FL_N = 7;

    localparam logic [DW-1:0] OFS_NMI_DEF = 8'hFA;
    localparam logic [DW-1:0] OFS_RES_DEF = 8'hFC;
    localparam logic [DW-1:0] OFS_IRQ_DEF = 8'hFE;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPER, ST_PSH_H, ST_PSH_L, ST_PSH_P, ST_VEC_L, ST_VEC_H
    } seq_st_e;

    typedef enum logic [2:0] {
        RQ_NONE, RQ_RES, RQ_NMI, RQ_IRQ, RQ_SWI
    } req_kind_e;

    typedef struct packed {
        logic          act;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
    } bus_cyc_t;

    function automatic logic is_push(seq_st_e s);
        return (s == ST_PSH_H) || (s == ST_PSH_L) || (s == ST_PSH_P);
    endfunction

    function automatic req_kind_e pick_req(logic res, logic nmi, logic irq);
        if (res)      return RQ_RES;
        else if (nmi) return RQ_NMI;
        else if (irq) return RQ_IRQ;
        else          return RQ_NONE;
    endfunction

endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter
    import ies_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      res_n,
    input  logic      nmi_n,
    input  logic      irq_n,
    input  logic      i_flag,
    input  logic      clr_res,
    input  logic      clr_nmi,
    output req_kind_e req
);

    logic nmi_q;
    logic res_pend;
    logic nmi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b1;
            res_pend <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_n;
            // a new request wins over the clear in the same cycle
            res_pend <= !res_n || (res_pend && !clr_res);
            nmi_pend <= (nmi_q && !nmi_n) || (nmi_pend && !clr_nmi);
        end
    end

    assign req = pick_req(res_pend, nmi_pend, !irq_n && !i_flag);

endmodule

// File: rtl/ies_regs.sv
module ies_regs
    import ies_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          so_n,
    input  logic          p_load,
    input  logic [DW-1:0] p_data,
    input  logic          set_i,
    input  logic          s_dec,
    output logic [DW-1:0] p_q,
    output logic [DW-1:0] s_q
);

    logic [DW-1:0] p_nx;

    always_comb begin
        p_nx = p_q;
        if (p_load) begin
            p_nx       = p_data;
            p_nx[FL_B] = 1'b0;
            p_nx[FL_R] = 1'b1;
        end
        if (!so_n)
            p_nx[FL_V] = 1'b1;
        if (set_i)
            p_nx[FL_I] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= DW'(1) << FL_R;
            s_q <= '1;
        end else begin
            p_q <= p_nx;
            if (s_dec)
                s_q <= s_q - DW'(1);
        end
    end

endmodule

// File: rtl/ies_seq.sv
module ies_seq
    import ies_pkg::*;
#(
    parameter logic [DW-1:0] STK_PAGE = 8'h01,
    parameter logic [DW-1:0] VEC_PAGE = 8'hFF,
    parameter logic [DW-1:0] OFS_RES  = OFS_RES_DEF,
    parameter logic [DW-1:0] OFS_NMI  = OFS_NMI_DEF,
    parameter logic [DW-1:0] OFS_IRQ  = OFS_IRQ_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rdy,
    input  logic          fetch_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] data_i,
    input  req_kind_e     req,
    input  logic [DW-1:0] p_cur,
    input  logic [DW-1:0] s_cur,
    output bus_cyc_t      bus,
    output logic          force_o,
    output logic          set_i,
    output logic          s_dec,
    output logic          clr_res,
    output logic          clr_nmi,
    output logic [AW-1:0] pc_o,
    output logic          pc_load_o,
    output seq_st_e       st_o,
    output req_kind_e     kind_o
);

    seq_st_e       st_q, st_nx;
    req_kind_e     kind_q;
    logic [AW-1:0] base_q, push_pc, pc_q;
    logic [DW-1:0] lo_q, vec_ofs, push_p;
    logic          pcld_q, take;

    assign take    = (st_q == ST_IDLE) && fetch_i && rdy &&
                     ((req != RQ_NONE) || (data_i == '0));
    assign push_pc = (kind_q == RQ_SWI) ? base_q + AW'(2) : base_q;

    always_comb begin
        case (kind_q)
            RQ_RES:  vec_ofs = OFS_RES;
            RQ_NMI:  vec_ofs = OFS_NMI;
            default: vec_ofs = OFS_IRQ;
        endcase
    end

    always_comb begin
        push_p       = p_cur;
        push_p[FL_R] = 1'b1;
        push_p[FL_B] = (kind_q == RQ_SWI);
    end

    always_comb begin
        case (st_q)
            ST_IDLE:  st_nx = take ? ST_OPER : ST_IDLE;
            ST_OPER:  st_nx = ST_PSH_H;
            ST_PSH_H: st_nx = ST_PSH_L;
            ST_PSH_L: st_nx = ST_PSH_P;
            ST_PSH_P: st_nx = ST_VEC_L;
            ST_VEC_L: st_nx = ST_VEC_H;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        bus    = '0;
        bus.rd = 1'b1;
        case (st_q)
            ST_OPER: begin
                bus.act  = 1'b1;
                bus.addr = base_q + AW'(1);
            end
            ST_PSH_H, ST_PSH_L, ST_PSH_P: begin
                bus.act  = 1'b1;
                bus.rd   = (kind_q == RQ_RES);
                bus.addr = {STK_PAGE, s_cur};
                bus.wd   = (st_q == ST_PSH_H) ? push_pc[AW-1:DW] :
                           (st_q == ST_PSH_L) ? push_pc[DW-1:0] : push_p;
            end
            ST_VEC_L: begin
                bus.act  = 1'b1;
                bus.addr = {VEC_PAGE, vec_ofs};
            end
            ST_VEC_H: begin
                bus.act  = 1'b1;
                bus.addr = {VEC_PAGE, vec_ofs + DW'(1)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            kind_q <= RQ_NONE;
            base_q <= '0;
            lo_q   <= '0;
            pc_q   <= '0;
            pcld_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            pcld_q <= 1'b0;
            if (take) begin
                kind_q <= (req != RQ_NONE) ? req : RQ_SWI;
                base_q <= pc_i;
            end
            if (st_q == ST_VEC_L)
                lo_q <= data_i;
            if (st_q == ST_VEC_H) begin
                pc_q   <= {data_i, lo_q};
                pcld_q <= 1'b1;
            end
        end
    end

    assign s_dec     = is_push(st_q);
    assign set_i     = (st_q == ST_VEC_L);
    assign clr_res   = (st_q == ST_VEC_H) && (kind_q == RQ_RES);
    assign clr_nmi   = (st_q == ST_VEC_H) && (kind_q == RQ_NMI);
    assign force_o   = (st_q != ST_IDLE) && (kind_q != RQ_SWI);
    assign pc_o      = pc_q;
    assign pc_load_o = pcld_q;
    assign st_o      = st_q;
    assign kind_o    = kind_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter logic [DW-1:0] STK_PAGE = 8'h01,
    parameter logic [DW-1:0] VEC_PAGE = 8'hFF,
    parameter logic [DW-1:0] OFS_RES  = OFS_RES_DEF,
    parameter logic [DW-1:0] OFS_NMI  = OFS_NMI_DEF,
    parameter logic [DW-1:0] OFS_IRQ  = OFS_IRQ_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_n,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          so_n,
    input  logic          rdy,
    input  logic          fetch_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] data_i,
    input  logic          p_load_i,
    input  logic [DW-1:0] p_data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rw_o,
    output logic          bus_act_o,
    output logic          force_o,
    output logic [AW-1:0] pc_o,
    output logic          pc_load_o,
    output logic [DW-1:0] p_o,
    output logic [DW-1:0] s_o
);

    req_kind_e req, kind;
    seq_st_e   st;
    bus_cyc_t  bus;
    logic      set_i, s_dec, clr_res, clr_nmi;

    ies_arbiter u_arb (
        .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .i_flag(p_o[FL_I]), .clr_res(clr_res), .clr_nmi(clr_nmi), .req(req)
    );

    ies_seq #(
        .STK_PAGE(STK_PAGE), .VEC_PAGE(VEC_PAGE),
        .OFS_RES(OFS_RES), .OFS_NMI(OFS_NMI), .OFS_IRQ(OFS_IRQ)
    ) u_seq (
        .clk(clk), .rst(rst), .rdy(rdy), .fetch_i(fetch_i), .pc_i(pc_i),
        .data_i(data_i), .req(req), .p_cur(p_o), .s_cur(s_o), .bus(bus),
        .force_o(force_o), .set_i(set_i), .s_dec(s_dec), .clr_res(clr_res),
        .clr_nmi(clr_nmi), .pc_o(pc_o), .pc_load_o(pc_load_o),
        .st_o(st), .kind_o(kind)
    );

    ies_regs u_regs (
        .clk(clk), .rst(rst), .so_n(so_n), .p_load(p_load_i), .p_data(p_data_i),
        .set_i(set_i), .s_dec(s_dec), .p_q(p_o), .s_q(s_o)
    );

    assign addr_o    = bus.addr;
    assign wdata_o   = bus.wd;
    assign rw_o      = bus.rd;
    assign bus_act_o = bus.act;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import ies_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          rdy,
    input logic          so_n,
    input logic          rw_o,
    input logic          force_o,
    input logic          pc_load_o,
    input logic [DW-1:0] p_o,
    input logic [DW-1:0] s_o,
    input seq_st_e       st,
    input req_kind_e     kind
);

    assert_s_step_R5: assert property (@(posedge clk) disable iff (rst)
        is_push(st) |=> (s_o == $past(s_o) - DW'(1)));

    assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (is_push(st) && kind == RQ_RES) |-> rw_o);

    assert_i_set_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VEC_H) |-> p_o[FL_I]);

    assert_pcld_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o);

    assert_rdy_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !rdy) |=> (st == ST_IDLE));

    assert_force_busy_R4: assert property (@(posedge clk) disable iff (rst)
        force_o |-> (st != ST_IDLE));

    assert_so_sets_v_R12: assert property (@(posedge clk) disable iff (rst)
        !so_n |=> p_o[FL_V]);

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk(clk), .rst(rst), .rdy(rdy), .so_n(so_n), .rw_o(rw_o),
    .force_o(force_o), .pc_load_o(pc_load_o), .p_o(p_o), .s_o(s_o),
    .st(st), .kind(kind)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    typedef struct packed {
        logic       ra;
        logic       na;
        logic       ia;
        logic [7:0] pv;
        logic [7:0] opc;
        logic [2:0] ek;   // 0 none, 1 reset, 2 nmi, 3 irq, 4 software break
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'hA9, 3'd1},
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hEA, 3'd2},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h4C, 3'd3},
        '{1'b0, 1'b0, 1'b1, 8'h04, 8'h4C, 3'd0},
        '{1'b0, 1'b0, 1'b0, 8'h81, 8'h00, 3'd4},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hEA, 3'd1},
        '{1'b0, 1'b0, 1'b0, 8'h04, 8'hEA, 3'd2},
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'h18, 3'd2},
        '{1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 3'd3},
        '{1'b0, 1'b0, 1'b0, 8'h00, 8'hEA, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, so_n = 1'b1, rdy = 1'b1;
    logic        fetch_i = 1'b0, p_load_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  p_data_i = '0, data_drv = '0;
    logic [7:0]  data_i;
    logic [15:0] addr_o, pc_o;
    logic [7:0]  wdata_o, p_o, s_o;
    logic        rw_o, bus_act_o, force_o, pc_load_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign data_i = bus_act_o ? mem(addr_o) : data_drv;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .so_n(so_n), .rdy(rdy), .fetch_i(fetch_i), .pc_i(pc_i), .data_i(data_i),
        .p_load_i(p_load_i), .p_data_i(p_data_i), .addr_o(addr_o),
        .wdata_o(wdata_o), .rw_o(rw_o), .bus_act_o(bus_act_o), .force_o(force_o),
        .pc_o(pc_o), .pc_load_o(pc_load_o), .p_o(p_o), .s_o(s_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_entry(input logic ra, input logic na, input logic ia,
                            input logic [7:0] pv, input logic [7:0] opc,
                            input int ek, input logic [15:0] pc0, input string tag);
        logic [7:0]  sb, pexp, vo;
        logic [15:0] ppc, vaddr;
        @(negedge clk);
        p_load_i = 1'b1; p_data_i = pv;
        if (ra) res_n = 1'b0;
        if (na) nmi_n = 1'b0;
        @(negedge clk);
        p_load_i = 1'b0;
        if (ra) res_n = 1'b1;
        if (na) nmi_n = 1'b1;
        irq_n = !ia; fetch_i = 1'b1; data_drv = opc; pc_i = pc0;
        sb   = s_o;
        pexp = (pv | 8'h20) & 8'hEF;
        chk(p_o == pexp, "R14 status load", p_o, pexp);
        @(negedge clk);
        fetch_i = 1'b0;
        if (ek == 0) begin
            chk(!bus_act_o && !force_o, tag, {bus_act_o, force_o}, 0);
            irq_n = 1'b1;
            return;
        end
        ppc = (ek == 4) ? pc0 + 16'd2 : pc0;
        vo  = (ek == 1) ? 8'hFC : (ek == 2) ? 8'hFA : 8'hFE;
        // operand cycle
        chk(bus_act_o && rw_o && addr_o == pc0 + 16'd1, "R8 operand read", addr_o, pc0 + 16'd1);
        chk(force_o == (ek != 4), "R4 forced indication", force_o, (ek != 4));
        @(negedge clk);
        chk(addr_o == {8'h01, sb} && wdata_o == ppc[15:8], "R5 push pc high",
            {addr_o, wdata_o}, {8'h01, sb, ppc[15:8]});
        chk(rw_o == (ek == 1), "R6 stack write strobe", rw_o, (ek == 1));
        @(negedge clk);
        chk(addr_o == {8'h01, sb - 8'd1} && wdata_o == ppc[7:0], "R8 push pc low",
            {addr_o, wdata_o}, {8'h01, sb - 8'd1, ppc[7:0]});
        @(negedge clk);
        chk(addr_o == {8'h01, sb - 8'd2} && wdata_o == (pexp | ((ek == 4) ? 8'h10 : 8'h00)),
            "R7 pushed status", {addr_o, wdata_o},
            {8'h01, sb - 8'd2, pexp | ((ek == 4) ? 8'h10 : 8'h00)});
        irq_n = 1'b1;
        @(negedge clk);
        vaddr = {8'hFF, vo};
        chk(rw_o && addr_o == vaddr, "R2 vector low address", addr_o, vaddr);
        @(negedge clk);
        chk(p_o[2] == 1'b1, "R9 I flag set", p_o, 8'h04);
        @(negedge clk);
        chk(pc_load_o && pc_o == {mem(vaddr + 16'd1), mem(vaddr)}, "R9 new pc",
            {pc_load_o, pc_o}, {1'b1, mem(vaddr + 16'd1), mem(vaddr)});
        chk(s_o == sb - 8'd3 && !bus_act_o, "R5 stack pointer end", s_o, sb - 8'd3);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(p_o == 8'h20 && s_o == 8'hFF, "R1 status and stack reset", {p_o, s_o}, 16'h20FF);
        chk(!bus_act_o && !force_o && rw_o, "R1 bus idle", {bus_act_o, force_o, rw_o}, 3'b001);

        for (int i = 0; i < NV; i++) begin
            do_entry(TBL[i].ra, TBL[i].na, TBL[i].ia, TBL[i].pv, TBL[i].opc,
                     int'(TBL[i].ek), (i == 4) ? 16'h12FF : 16'h2000 + 16'(i * 37),
                     "R3 no entry expected");
        end

        // R13: rdy low hides the fetch; the reset request stays pending
        @(negedge clk); res_n = 1'b0;
        @(negedge clk); res_n = 1'b1; fetch_i = 1'b1; rdy = 1'b0; data_drv = 8'hEA;
        @(negedge clk); fetch_i = 1'b0; rdy = 1'b1;
        chk(!bus_act_o && !force_o, "R13 fetch ignored while not ready", bus_act_o, 0);
        do_entry(1'b0, 1'b0, 1'b0, 8'h00, 8'hEA, 1, 16'h4400, "R13");
        // R11: the reset request is gone after its vector load
        do_entry(1'b0, 1'b0, 1'b0, 8'h00, 8'hEA, 0, 16'h4410, "R11 reset request cleared");

        // R10: held-low NMI enters once
        @(negedge clk); nmi_n = 1'b0;
        @(negedge clk);
        do_entry(1'b0, 1'b0, 1'b0, 8'h00, 8'hEA, 2, 16'h5000, "R10");
        do_entry(1'b0, 1'b0, 1'b0, 8'h00, 8'hEA, 0, 16'h5010, "R10 held nmi retaken");
        nmi_n = 1'b1;

        // R12: set-overflow pin
        @(negedge clk); p_load_i = 1'b1; p_data_i = 8'h00;
        @(negedge clk); p_load_i = 1'b0;
        chk(p_o[6] == 1'b0, "R12 V clear before pin", p_o, 8'h20);
        so_n = 1'b0;
        @(negedge clk); so_n = 1'b1;
        chk(p_o[6] == 1'b1, "R12 V set by pin", p_o, 8'h60);

        // R14: break marker cleared, reserved bit forced on load
        p_load_i = 1'b1; p_data_i = 8'hD0;
        @(negedge clk); p_load_i = 1'b0;
        chk(p_o == 8'hE0, "R14 forced bits on load", p_o, 8'hE0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule